// File: doc/BRIEF.md
# Banked Row-to-Column Transpose Memory

This block turns a square, zero-padded matrix that arrives row by row into a stream that leaves column by column. It sits between two groups of parallel transform engines: the first group produces rows, the second consumes columns. The matrix edge `NPAD` must be a multiple of the lane count (five by default), for example 20 for a 16×16 test matrix or 260 for a 256×256 production matrix. Each of the five input lanes carries one row of a group of five consecutive rows, one complex sample per beat. Each of the five output lanes carries one column of a group of five consecutive columns.

Storage is split into five dual-ported banks. Element (row i, column j) lives in bank (i + j) mod 5, at word (i / 5)·NPAD + j within the frame area. With this layout the five samples written in one cycle (same column, five consecutive rows) and the five samples read in one cycle (same row, five consecutive columns) always fall into five different banks. Two frame areas are used in ping-pong, so one frame can be read out while the next is written in. The input lanes advance in lockstep, and so do the output lanes, each with its own valid/ready handshake.

Top module: `transpose_banked`

## Requirements
- R1: After reset no output lane is valid, and both frame areas are free, so all in_ready bits rise as soon as every in_valid bit is high.
- R2: The input lanes move in lockstep: every in_ready bit is high only when all in_valid bits are high and a frame area is free, and otherwise all are low.
- R3: Input lane L, on beat m of a frame, carries element (row 5·(m / NPAD) + L, column m mod NPAD). Output lane L, on beat k of a frame, delivers the element at row k mod NPAD and column 5·(k / NPAD) + L of the same frame. Frames leave in the order they were written.
- R4: The padding rows and columns (index ≥ NPAD − 4 in the test matrix) return exactly the values written there, which are zeros in normal use.
- R5: out_last of lane L is high exactly on beats where the row index is NPAD − 1, which is the last sample of a column.
- R6: out_sof of lane L is high exactly on beat 0 of each frame.
- R7: While out_valid of a lane is high and its out_ready is low, that lane's data, last and sof stay unchanged. Lanes may accept at different cycles without losing or repeating samples.
- R8: A frame becomes readable only after its last input beat is accepted. When the output side is idle, the first output beat is valid in the third cycle after the edge that accepted that last beat. While both frame areas hold unread frames, in_ready stays low.
- R9: A beat with in_sof high is stored as column 0 of rows 0 to 4 of a new frame. This discards the position of any unfinished frame in progress.
- R10: With in_valid held high and a free frame area, a frame's NPAD²/5 input beats are accepted on consecutive cycles. With out_ready held high, a stored frame's NPAD²/5 output beats leave on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | LANES | Per-lane input valid |
| in_ready | output | LANES | Per-lane input ready (all equal) |
| in_data | input | LANES×DW | Per-lane complex sample, row-major |
| in_sof | input | 1 | Marks the first beat of an input frame |
| out_valid | output | LANES | Per-lane output valid |
| out_ready | input | LANES | Per-lane output ready |
| out_data | output | LANES×DW | Per-lane complex sample, column-major |
| out_last | output | LANES | Last sample of a column |
| out_sof | output | LANES | First beat of an output frame |

## Verification
The bound checker watches, on every cycle, the lockstep rule for in_ready, the block on writes while both frame areas are full, the rule that a frame area turns full only right after a final write, stable output under backpressure, and the positions of out_last and out_sof, counted per lane. The transposed index of every sample, the handling of padding, the restart on in_sof, the ping-pong order and the cycle counts for sustained throughput can only be shown by the bench's frame scenarios. The bench compares each output against values it computes from the coordinate formulas.

// File: rtl/tp_pkg.sv
package tp_pkg;

    // State of one ping-pong frame area
    typedef enum logic {
        BUF_FREE = 1'b0,
        BUF_FULL = 1'b1
    } buf_state_e;

    // (a + b) mod m for 0 <= a, b < m
    function automatic int ring_add(input int a, input int b, input int m);
        int s;
        s = a + b;
        return (s >= m) ? s - m : s;
    endfunction

endpackage

// File: rtl/tp_bank.sv
// One bank: a single write port and a single registered read port
module tp_bank #(
    parameter int DW = 32,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        if (re) rdata_q <= mem[raddr];
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/tp_wr_ctrl.sv
// Row-major write side: tracks column, row group and column mod lane count,
// rotates lane data onto banks.
module tp_wr_ctrl import tp_pkg::*; #(
    parameter int LANES = 5,
    parameter int NPAD  = 20,
    parameter int DW    = 32,
    parameter int AW    = 7
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       buf_open,
    input  logic [LANES-1:0]           in_valid,
    input  logic [LANES-1:0][DW-1:0]   in_data,
    input  logic                       in_sof,
    output logic [LANES-1:0]           in_ready,
    output logic                       bank_we,
    output logic [AW-1:0]              bank_waddr,
    output logic [LANES-1:0][DW-1:0]   bank_wdata,
    output logic                       frame_done
);
    localparam int CW   = $clog2(NPAD);
    localparam int RW   = $clog2(LANES);
    localparam int NGRP = NPAD / LANES;
    localparam logic [CW-1:0] COL_END  = CW'(NPAD - 1);
    localparam logic [AW-1:0] BASE_END = AW'((NGRP - 1) * NPAD);
    localparam logic [AW-1:0] BASE_STEP = AW'(NPAD);

    typedef struct packed {
        logic [CW-1:0] col;
        logic [RW-1:0] rot;
        logic [AW-1:0] base;
    } wr_state_t;

    wr_state_t st_q, st_d;

    logic          fire;
    logic          at_last;
    logic [CW-1:0] eff_col;
    logic [RW-1:0] eff_rot;
    logic [AW-1:0] eff_base;

    always_comb begin
        st_d     = st_q;
        fire     = buf_open && (&in_valid);
        eff_col  = in_sof ? '0 : st_q.col;
        eff_rot  = in_sof ? '0 : st_q.rot;
        eff_base = in_sof ? '0 : st_q.base;
        at_last  = (eff_col == COL_END) && (eff_base == BASE_END);

        in_ready   = {LANES{fire}};
        bank_we    = fire;
        bank_waddr = eff_base + AW'(eff_col);
        frame_done = fire && at_last;

        // lane l holds row (group*LANES + l); bank = (l + col) mod LANES
        for (int b = 0; b < LANES; b++) begin
            bank_wdata[b] = '0;
            for (int l = 0; l < LANES; l++) begin
                if (ring_add(l, int'(eff_rot), LANES) == b) bank_wdata[b] = in_data[l];
            end
        end

        if (fire) begin
            if (at_last) begin
                st_d = '0;
            end else if (eff_col == COL_END) begin
                st_d.col  = '0;
                st_d.rot  = '0;
                st_d.base = eff_base + BASE_STEP;
            end else begin
                st_d.col  = eff_col + CW'(1);
                st_d.rot  = RW'(ring_add(int'(eff_rot), 1, LANES));
                st_d.base = eff_base;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/tp_rd_ctrl.sv
// Column-major read side: address generation, one-cycle bank latency stage,
// per-lane output holding registers with independent handshakes.
module tp_rd_ctrl import tp_pkg::*; #(
    parameter int LANES = 5,
    parameter int NPAD  = 20,
    parameter int DW    = 32,
    parameter int AW    = 7
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       buf_avail,
    output logic                       rd_issue,
    output logic                       frame_done,
    output logic [LANES-1:0][AW-1:0]   bank_raddr,
    input  logic [LANES-1:0][DW-1:0]   bank_rdata,
    input  logic [LANES-1:0]           out_ready,
    output logic [LANES-1:0]           out_valid,
    output logic [LANES-1:0][DW-1:0]   out_data,
    output logic [LANES-1:0]           out_last,
    output logic [LANES-1:0]           out_sof
);
    localparam int CW = $clog2(NPAD);
    localparam int RW = $clog2(LANES);
    localparam logic [CW-1:0] ROW_END     = CW'(NPAD - 1);
    localparam logic [RW-1:0] ROT_END     = RW'(LANES - 1);
    localparam logic [AW-1:0] COLBASE_END = AW'(NPAD - LANES);
    localparam logic [AW-1:0] ROW_STEP    = AW'(NPAD);
    localparam logic [AW-1:0] COL_STEP    = AW'(LANES);

    typedef struct packed {
        logic [CW-1:0]           row;
        logic [RW-1:0]           rot;
        logic [AW-1:0]           rowbase;
        logic [AW-1:0]           colbase;
        logic                    s1_v;
        logic [RW-1:0]           s1_rot;
        logic                    s1_last;
        logic                    s1_sof;
        logic [LANES-1:0]        s2_v;
        logic [LANES-1:0][DW-1:0] s2_data;
        logic [LANES-1:0]        s2_last;
        logic [LANES-1:0]        s2_sof;
    } rd_state_t;

    rd_state_t st_q, st_d;

    logic can_load;
    logic s1_move;
    logic row_end;

    always_comb begin
        st_d = st_q;

        can_load = 1'b1;
        for (int l = 0; l < LANES; l++) begin
            if (st_q.s2_v[l] && !out_ready[l]) can_load = 1'b0;
        end
        s1_move    = st_q.s1_v && can_load;
        rd_issue   = buf_avail && (!st_q.s1_v || s1_move);
        row_end    = (st_q.row == ROW_END);
        frame_done = rd_issue && row_end && (st_q.colbase == COLBASE_END);

        // lane l reads column (colbase + l); its bank is (row + l) mod LANES
        for (int b = 0; b < LANES; b++) begin
            bank_raddr[b] = '0;
            for (int l = 0; l < LANES; l++) begin
                if (ring_add(l, int'(st_q.rot), LANES) == b)
                    bank_raddr[b] = st_q.rowbase + st_q.colbase + AW'(l);
            end
        end

        // output holding registers drain lane by lane
        for (int l = 0; l < LANES; l++) begin
            if (st_q.s2_v[l] && out_ready[l]) st_d.s2_v[l] = 1'b0;
        end

        if (s1_move) begin
            st_d.s1_v = 1'b0;
            for (int l = 0; l < LANES; l++) begin
                st_d.s2_v[l]    = 1'b1;
                st_d.s2_last[l] = st_q.s1_last;
                st_d.s2_sof[l]  = st_q.s1_sof;
                st_d.s2_data[l] = '0;
                for (int b = 0; b < LANES; b++) begin
                    if (ring_add(l, int'(st_q.s1_rot), LANES) == b)
                        st_d.s2_data[l] = bank_rdata[b];
                end
            end
        end

        if (rd_issue) begin
            st_d.s1_v    = 1'b1;
            st_d.s1_rot  = st_q.rot;
            st_d.s1_last = row_end;
            st_d.s1_sof  = (st_q.row == '0) && (st_q.colbase == '0);
            if (row_end) begin
                st_d.row     = '0;
                st_d.rot     = '0;
                st_d.rowbase = '0;
                st_d.colbase = frame_done ? '0 : st_q.colbase + COL_STEP;
            end else begin
                st_d.row = st_q.row + CW'(1);
                if (st_q.rot == ROT_END) begin
                    st_d.rot     = '0;
                    st_d.rowbase = st_q.rowbase + ROW_STEP;
                end else begin
                    st_d.rot = st_q.rot + RW'(1);
                end
            end
        end

        out_valid = st_q.s2_v;
        out_data  = st_q.s2_data;
        out_last  = st_q.s2_last;
        out_sof   = st_q.s2_sof;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/transpose_banked.sv
module transpose_banked import tp_pkg::*; #(
    parameter int LANES = 5,
    parameter int NPAD  = 20,
    parameter int DW    = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [LANES-1:0]          in_valid,
    output logic [LANES-1:0]          in_ready,
    input  logic [LANES-1:0][DW-1:0]  in_data,
    input  logic                      in_sof,
    output logic [LANES-1:0]          out_valid,
    input  logic [LANES-1:0]          out_ready,
    output logic [LANES-1:0][DW-1:0]  out_data,
    output logic [LANES-1:0]          out_last,
    output logic [LANES-1:0]          out_sof
);
    localparam int NGRP  = NPAD / LANES;
    localparam int WORDS = NGRP * NPAD;
    localparam int AW    = $clog2(WORDS);

    typedef struct packed {
        buf_state_e [1:0] full;
        logic             wsel;
        logic             rsel;
    } pp_state_t;

    pp_state_t st_q, st_d;

    logic                      wr_open;
    logic                      rd_avail;
    logic                      wr_we;
    logic [AW-1:0]             wr_addr;
    logic [LANES-1:0][DW-1:0]  wr_data;
    logic                      wr_done;
    logic                      rd_issue;
    logic                      rd_done;
    logic [LANES-1:0][AW-1:0]  rd_addr;
    logic [LANES-1:0][DW-1:0]  rd_data;
    logic [1:0]                buf_full;

    // ping-pong ownership of the two frame areas
    always_comb begin
        st_d     = st_q;
        wr_open  = (st_q.full[st_q.wsel] == BUF_FREE);
        rd_avail = (st_q.full[st_q.rsel] == BUF_FULL);
        if (wr_done) begin
            st_d.full[st_q.wsel] = BUF_FULL;
            st_d.wsel            = ~st_q.wsel;
        end
        if (rd_done) begin
            st_d.full[st_q.rsel] = BUF_FREE;
            st_d.rsel            = ~st_q.rsel;
        end
        for (int k = 0; k < 2; k++) buf_full[k] = (st_q.full[k] == BUF_FULL);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    tp_wr_ctrl #(.LANES(LANES), .NPAD(NPAD), .DW(DW), .AW(AW)) u_wr (
        .clk        (clk),
        .rst_n      (rst_n),
        .buf_open   (wr_open),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .in_sof     (in_sof),
        .in_ready   (in_ready),
        .bank_we    (wr_we),
        .bank_waddr (wr_addr),
        .bank_wdata (wr_data),
        .frame_done (wr_done)
    );

    tp_rd_ctrl #(.LANES(LANES), .NPAD(NPAD), .DW(DW), .AW(AW)) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .buf_avail  (rd_avail),
        .rd_issue   (rd_issue),
        .frame_done (rd_done),
        .bank_raddr (rd_addr),
        .bank_rdata (rd_data),
        .out_ready  (out_ready),
        .out_valid  (out_valid),
        .out_data   (out_data),
        .out_last   (out_last),
        .out_sof    (out_sof)
    );

    for (genvar b = 0; b < LANES; b++) begin : g_bank
        tp_bank #(.DW(DW), .AW(AW + 1)) u_bank (
            .clk   (clk),
            .we    (wr_we),
            .waddr ({st_q.wsel, wr_addr}),
            .wdata (wr_data[b]),
            .re    (rd_issue),
            .raddr ({st_q.rsel, rd_addr[b]}),
            .rdata (rd_data[b])
        );
    end
endmodule

// File: rtl/tp_checker.sv
module tp_checker #(
    parameter int LANES = 5,
    parameter int NPAD  = 20,
    parameter int DW    = 32
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [LANES-1:0]          in_valid,
    input logic [LANES-1:0]          in_ready,
    input logic [LANES-1:0]          out_valid,
    input logic [LANES-1:0]          out_ready,
    input logic [LANES-1:0][DW-1:0]  out_data,
    input logic [LANES-1:0]          out_last,
    input logic [LANES-1:0]          out_sof,
    input logic [1:0]                buf_full,
    input logic                      wr_done
);
    localparam int FBEATS = NPAD * NPAD / LANES;
    localparam int CW = $clog2(NPAD);
    localparam int FW = $clog2(FBEATS);

    logic [LANES-1:0][CW-1:0] row_cnt;
    logic [LANES-1:0][FW-1:0] beat_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_cnt  <= '0;
            beat_cnt <= '0;
        end else begin
            for (int l = 0; l < LANES; l++) begin
                if (out_valid[l] && out_ready[l]) begin
                    row_cnt[l]  <= (row_cnt[l] == CW'(NPAD - 1)) ? '0 : row_cnt[l] + CW'(1);
                    beat_cnt[l] <= (beat_cnt[l] == FW'(FBEATS - 1)) ? '0 : beat_cnt[l] + FW'(1);
                end
            end
        end
    end

    AST_READY_NEEDS_ALL_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready != '0) |-> (&in_valid)); // R2

    AST_NO_ACCEPT_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_full == 2'b11) |-> (in_ready == '0)); // R8

    for (genvar k = 0; k < 2; k++) begin : g_area
        AST_HANDOVER_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(buf_full[k]) |-> $past(wr_done)); // R8
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid[l] && !out_ready[l]) |=>
                (out_valid[l] && $stable(out_data[l]) && $stable(out_last[l]) && $stable(out_sof[l]))); // R7

        AST_LAST_AT_COLUMN_END: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[l] |-> (out_last[l] == (row_cnt[l] == CW'(NPAD - 1)))); // R5

        AST_SOF_AT_FRAME_START: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[l] |-> (out_sof[l] == (beat_cnt[l] == '0))); // R6
    end
endmodule

bind transpose_banked tp_checker #(.LANES(LANES), .NPAD(NPAD), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_last  (out_last),
    .out_sof   (out_sof),
    .buf_full  (buf_full),
    .wr_done   (wr_done)
);

// File: tb/tb_transpose_banked.sv
module tb_transpose_banked;
    localparam int CLK_PERIOD = 10;
    localparam int LANES  = 5;
    localparam int NPAD   = 20;
    localparam int NREAL  = NPAD - 4;
    localparam int DW     = 32;
    localparam int FB     = NPAD * NPAD / LANES;
    localparam int NTBL   = 4;

    // stimulus table: frame seed, output ready mode, input gap period, frames done after entry
    localparam int TBL_SEED  [NTBL] = '{11, 22, 33, 44};
    localparam int TBL_RMODE [NTBL] = '{0, 1, 1, 3};
    localparam int TBL_GAP   [NTBL] = '{0, 0, 3, 7};
    localparam int TBL_DONE  [NTBL] = '{1, 2, 3, 4};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [LANES-1:0]         in_valid = '0;
    logic [LANES-1:0]         in_ready;
    logic [LANES-1:0][DW-1:0] in_data = '0;
    logic                     in_sof = 1'b0;
    logic [LANES-1:0]         out_valid;
    logic [LANES-1:0]         out_ready = '0;
    logic [LANES-1:0][DW-1:0] out_data;
    logic [LANES-1:0]         out_last;
    logic [LANES-1:0]         out_sof;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int rdy_mode = 0;
    int n_sent = 0;
    int sent [64];
    int kb [LANES];
    int fi [LANES];
    int ft [64];
    int lt [64];
    int wr_f = 0;
    int wr_l = 0;
    logic [15:0] lfsr = 16'hACE1;

    transpose_banked #(.LANES(LANES), .NPAD(NPAD), .DW(DW)) dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_sof(in_sof),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_last(out_last), .out_sof(out_sof)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc++;

    function automatic logic [DW-1:0] elem(input int seed, input int i, input int j);
        if (i >= NREAL || j >= NREAL) return '0;
        return {seed[7:0], i[11:0], j[11:0]};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    endtask

    // output monitor: drives out_ready, checks every transfer
    initial begin
        for (int l = 0; l < LANES; l++) begin kb[l] = 0; fi[l] = 0; end
        forever begin
            @(negedge clk);
            case (rdy_mode)
                0: out_ready = '1;
                1: out_ready = lfsr[LANES-1:0] | lfsr[LANES+2:3];
                2: out_ready = '0;
                default: begin
                    out_ready = '1;
                    out_ready[2] = (cyc % 4 == 0);
                end
            endcase
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            #1;
            for (int l = 0; l < LANES; l++) begin
                if (out_valid[l] && out_ready[l]) begin
                    int k, r, c;
                    logic [DW-1:0] e;
                    k = kb[l];
                    r = k % NPAD;
                    c = LANES * (k / NPAD) + l;
                    e = elem(sent[fi[l]], r, c);
                    if (r >= NREAL || c >= NREAL)
                        chk(out_data[l] == e, "R4 padding", 64'(out_data[l]), 64'(e));
                    else
                        chk(out_data[l] == e, "R3 transposed data", 64'(out_data[l]), 64'(e));
                    chk(out_last[l] == (r == NPAD - 1), "R5 last flag", 64'(out_last[l]), 64'(r == NPAD - 1));
                    chk(out_sof[l] == (k == 0), "R6 sof flag", 64'(out_sof[l]), 64'(k == 0));
                    if (l == 0 && k == 0) ft[fi[l]] = cyc;
                    if (l == 0 && k == FB - 1) lt[fi[l]] = cyc;
                    if (k == FB - 1) begin kb[l] = 0; fi[l]++; end
                    else kb[l] = k + 1;
                end
            end
        end
    end

    task automatic send_beats(input int seed, input int nbeats, input int gap, input bit push);
        if (push) begin sent[n_sent] = seed; n_sent++; end
        for (int m = 0; m < nbeats; m++) begin
            @(negedge clk);
            if (gap > 0 && (m % gap) == gap - 1) begin
                in_valid = '0; in_sof = 1'b0;
                @(negedge clk);
            end
            in_valid = '1;
            in_sof = (m == 0);
            for (int l = 0; l < LANES; l++) in_data[l] = elem(seed, LANES * (m / NPAD) + l, m % NPAD);
            #1;
            while (in_ready != '1) begin @(negedge clk); #1; end
            if (m == 0) wr_f = cyc;
            wr_l = cyc;
        end
        @(negedge clk);
        in_valid = '0;
        in_sof = 1'b0;
    endtask

    task automatic drain();
        bit done;
        done = 1'b0;
        while (!done) begin
            @(negedge clk); #2;
            done = 1'b1;
            for (int l = 0; l < LANES; l++) if (fi[l] != n_sent) done = 1'b0;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        summary();
        $finish;
    end

    initial begin
        int f55, f66, w55f, w55l, w66f, w66l;
        bit stalled;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 / R2: reset state and lockstep acceptance
        @(negedge clk); #1;
        chk(out_valid == '0, "R1 no output after reset", 64'(out_valid), 0);
        chk(in_ready == '0, "R2 no ready without valid", 64'(in_ready), 0);
        in_valid = 5'b00001; #1;
        chk(in_ready == '0, "R2 partial valid gives no ready", 64'(in_ready), 0);
        in_valid = '1; #1;
        chk(in_ready == '1, "R1 free area accepts", 64'(in_ready), 64'(5'b11111));
        in_valid = '0;

        // table walk: frames under different input gaps and output backpressure (R3 R4 R7)
        for (int t = 0; t < NTBL; t++) begin
            rdy_mode = TBL_RMODE[t];
            send_beats(TBL_SEED[t], FB, TBL_GAP[t], 1'b1);
            drain();
            chk(fi[0] == TBL_DONE[t] && fi[LANES-1] == TBL_DONE[t], "R7 frames complete under backpressure",
                64'(fi[0]), 64'(TBL_DONE[t]));
        end

        // R10 / R8: back-to-back frames, full rate, handover latency
        rdy_mode = 0;
        f55 = n_sent;
        send_beats(55, FB, 0, 1'b1);
        w55f = wr_f; w55l = wr_l;
        f66 = n_sent;
        send_beats(66, FB, 0, 1'b1);
        w66f = wr_f; w66l = wr_l;
        drain();
        chk(w55l - w55f == FB - 1, "R10 write rate frame A", 64'(w55l - w55f), 64'(FB - 1));
        chk(w66l - w66f == FB - 1, "R10 write rate frame B", 64'(w66l - w66f), 64'(FB - 1));
        chk(lt[f55] - ft[f55] == FB - 1, "R10 read rate frame A", 64'(lt[f55] - ft[f55]), 64'(FB - 1));
        chk(lt[f66] - ft[f66] == FB - 1, "R10 read rate frame B", 64'(lt[f66] - ft[f66]), 64'(FB - 1));
        chk(ft[f55] - w55l == 3, "R8 first output after handover", 64'(ft[f55] - w55l), 3);

        // R8: both areas full blocks writes; order kept
        rdy_mode = 2;
        send_beats(77, FB, 0, 1'b1);
        send_beats(88, FB, 0, 1'b1);
        stalled = 1'b1;
        for (int c = 0; c < 10; c++) begin
            @(negedge clk);
            in_valid = '1; in_sof = 1'b1;
            #1;
            if (in_ready != '0) stalled = 1'b0;
        end
        chk(stalled, "R8 no acceptance while both areas full", 64'(in_ready), 0);
        chk(out_valid == '1, "R8 stored frame waits at output", 64'(out_valid), 64'(5'b11111));
        in_valid = '0; in_sof = 1'b0;
        rdy_mode = 0;
        send_beats(99, FB, 0, 1'b1);
        drain();
        chk(fi[0] == n_sent, "R8 three frames delivered in order", 64'(fi[0]), 64'(n_sent));

        // R9: unfinished frame then restart with in_sof
        rdy_mode = 1;
        send_beats(123, 13, 0, 1'b0);
        send_beats(124, FB, 2, 1'b1);
        drain();
        chk(fi[2] == n_sent && kb[2] == 0, "R9 restart leaves no partial frame", 64'(fi[2]), 64'(n_sent));
        repeat (5) @(negedge clk);
        #1;
        chk(out_valid == '0, "R9 no stray output after restart", 64'(out_valid), 0);

        summary();
        $finish;
    end
endmodule